// File: doc/BRIEF.md
# Ten-to-One Parallel-to-Serial Tree

This block turns a ten-lane parallel word into one serial bit stream that runs ten times faster than the word rate. Only the fast bit clock is supplied. A phase counter inside the block divides it and produces the word-rate load strobe and the half-rate step strobes. The word on `par_in` is registered on the load strobe. Each half of the registered word goes to its own five-to-one multiphase selector, and each selector produces one stream at half the final rate. A last two-to-one stage interleaves the two streams into the output.

The upstream logic watches `word_ld` and holds its next word on `par_in` across the rising edge that ends a `word_ld` cycle. Whatever `par_in` carries at any other time is ignored. All rates are modelled as ratios of the single bit clock.

Top module: `ser10_tree`

## Requirements
- R1: `word_ld` is high for exactly one cycle in every ten. After `rst_n` is released, the first cycle (phase 0) has `word_ld` low, and `word_ld` is first high in the tenth cycle (phase 9).
- R2: The word captured is the value of `par_in` at the rising edge that ends a cycle with `word_ld` high.
- R3: Within one word, the bits leave in the lane order 0, 5, 1, 6, 2, 7, 3, 8, 4, 9, where lane n is `par_in[n]`. Lanes 0 to 4 pass through the first five-to-one unit and lanes 5 to 9 through the second.
- R4: Lane 0 of a captured word is on `ser_out` in the third cycle after its `word_ld` cycle. Each following bit comes one cycle later. Consecutive words follow one another with no gap.
- R5: Values on `par_in` in cycles other than the capture edge of R2 have no effect on `ser_out`.
- R6: A synchronous active-low reset returns the divider to phase 0 and holds `word_ld` low. `ser_out` stays low during reset and stays low after it until lane 0 of the first captured word is due under R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_in | input | 10 | Parallel word, one bit per lane |
| word_ld | output | 1 | Word-rate strobe; `par_in` is taken at the edge that ends this cycle |
| ser_out | output | 1 | Serial output, one bit per clock |

## Verification
The assertions assume that the divider phase never leaves the range 0 to 9. They also assume that `par_in` carries meaning only at the load edge, so they check that the captured word and each unit's output hold steady between strobes. The stimulus stays inside these limits by timing every directed or random word from the bench's own ten-cycle count. It fills every other cycle with random junk, which exercises the ignore rule while the inputs stay legal. A reset applied in the middle of a word checks that the phase restarts and that the output stays quiet until the first new word.

// File: rtl/ser10_pkg.sv
// Shared definitions for the ten-to-one serializer tree.
// Assumes a single bit clock; all slower rates are enables derived from it.
package ser10_pkg;

    // Which half-rate stream the final merge forwards in a given cycle.
    typedef enum logic {
        SRC_UNIT_LO = 1'b0,
        SRC_UNIT_HI = 1'b1
    } merge_src_e;

    // Map the divider's low phase bit to the stream to forward on the next edge.
    function automatic merge_src_e src_for_phase(input logic ph_odd);
        return ph_odd ? SRC_UNIT_LO : SRC_UNIT_HI;
    endfunction

endpackage

// File: rtl/ser10_clkdiv.sv
// Clock divider: a phase counter that wraps every LANES cycles.
// Produces the word-rate load enable (last phase) and the half-rate
// step enable (even phases). Assumes LANES is even.
module ser10_clkdiv #(
    parameter int LANES = 10,
    localparam int PW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] ph,
    output logic          word_en,
    output logic          half_en
);
    localparam logic [PW-1:0] LAST = PW'(LANES - 1);

    // Advance the phase, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)          ph <= '0;
        else if (ph == LAST) ph <= '0;
        else                 ph <= ph + 1'b1;
    end

    // Decode the rate enables from the phase.
    assign word_en = (ph == LAST);
    assign half_en = ~ph[0];

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= LAST); // R1
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        word_en |=> (ph == '0)); // R1
endmodule

// File: rtl/ser10_capture.sv
// Parallel receive register: takes the whole word on the load enable and
// holds it otherwise. 'armed' marks that at least one word was taken.
module ser10_capture #(
    parameter int LANES = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] cap_q,
    output logic             armed
);
    // Register the word on the load enable only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cap_q <= d;
            armed <= 1'b1;
        end
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cap_q)); // R5
    AST_CAPTURE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cap_q == $past(d))); // R2
endmodule

// File: rtl/ser10_mux5.sv
// Multiphase selector: on each step enable, registers the lane chosen by
// the step index. Its output changes at most once per two bit clocks.
// Assumes sel stays below GRP whenever step_en is high.
module ser10_mux5 #(
    parameter int GRP = 5,
    localparam int SW = $clog2(GRP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_en,
    input  logic [SW-1:0]  sel,
    input  logic [GRP-1:0] lanes,
    output logic           q
);
    localparam logic [SW-1:0] SEL_MAX = SW'(GRP - 1);

    // Register the selected lane on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (step_en) q <= lanes[sel];
    end

    AST_UNIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(q)); // R3
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> (sel <= SEL_MAX)); // R3
endmodule

// File: rtl/ser10_merge2.sv
// Final two-to-one merge: forwards the low unit's stream on odd phases and
// the high unit's on even phases, so the two streams alternate. Output is
// held low until the first word has been armed.
module ser10_merge2
    import ser10_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic ph_odd,
    input  logic lo_bit,
    input  logic hi_bit,
    output logic q
);
    merge_src_e src;

    // Pick the source stream for the coming edge.
    always_comb begin
        src = src_for_phase(ph_odd);
    end

    // Register the interleaved bit, quiet before the first word.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed)        q <= 1'b0;
        else if (src == SRC_UNIT_LO) q <= lo_bit;
        else                         q <= hi_bit;
    end

    AST_QUIET_UNTIL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !q); // R6
endmodule

// File: rtl/ser10_tree.sv
// Ten-to-one serializer tree: divider, parallel capture, two five-to-one
// multiphase units and a two-to-one merge, all on one bit clock.
// Assumes the upstream logic presents each word across the edge that
// ends a word_ld cycle.
module ser10_tree #(
    parameter int GRP = 5,
    localparam int LANES = 2 * GRP,
    localparam int PW = $clog2(LANES),
    localparam int SW = $clog2(GRP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] par_in,
    output logic             word_ld,
    output logic             ser_out
);
    logic [PW-1:0]    ph;
    logic             half_en;
    logic [LANES-1:0] cap_q;
    logic             armed;
    logic [SW-1:0]    step_sel;
    logic [1:0]       unit_q;
    logic [PW-1:0]    ph_half;

    ser10_clkdiv #(.LANES(LANES)) u_div (
        .clk(clk), .rst_n(rst_n), .ph(ph), .word_en(word_ld), .half_en(half_en)
    );

    ser10_capture #(.LANES(LANES)) u_cap (
        .clk(clk), .rst_n(rst_n), .load(word_ld), .d(par_in),
        .cap_q(cap_q), .armed(armed)
    );

    // Derive the step index (phase / 2) shared by both units.
    always_comb begin
        ph_half  = ph >> 1;
        step_sel = ph_half[SW-1:0];
    end

    // One multiphase unit per half of the captured word.
    for (genvar u = 0; u < 2; u++) begin : g_unit
        ser10_mux5 #(.GRP(GRP)) u_mux (
            .clk(clk), .rst_n(rst_n), .step_en(half_en), .sel(step_sel),
            .lanes(cap_q[u*GRP +: GRP]), .q(unit_q[u])
        );
    end

    ser10_merge2 u_merge (
        .clk(clk), .rst_n(rst_n), .armed(armed), .ph_odd(ph[0]),
        .lo_bit(unit_q[0]), .hi_bit(unit_q[1]), .q(ser_out)
    );
endmodule

// File: tb/ser10_tree_test.sv
`timescale 1ns/1ps
module ser10_tree_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] par_in = '0;
    logic       word_ld;
    logic       ser_out;

    ser10_tree uut (.clk(clk), .rst_n(rst_n), .par_in(par_in),
                    .word_ld(word_ld), .ser_out(ser_out));

    always #4 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    int    k = 0;
    bit    done = 0;
    bit    rv [32];
    bit    rb [32];
    string rt [32];

    // Lane sent in serial slot i: 0,5,1,6,...
    function automatic int lane_of(input int i);
        return (i % 2 == 0) ? i / 2 : 5 + i / 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at k=%0d: actual %0d expected %0d", tag, k, act, exp);
        end
    endtask

    task automatic prefill();
        for (int i = 0; i < 32; i++) begin
            rv[i] = 1; rb[i] = 0; rt[i] = "R6 quiet before first word";
        end
    endtask

    // Sample at the current negedge, drive the next input, advance one cycle.
    task automatic cyc(input logic [9:0] w, input string tag);
        bit ld_exp;
        ld_exp = (k % 10 == 9);
        chk(word_ld == ld_exp, "R1 word_ld cadence", int'(word_ld), int'(ld_exp));
        if (rv[k % 32]) begin
            chk(ser_out == rb[k % 32], rt[k % 32], int'(ser_out), int'(rb[k % 32]));
            rv[k % 32] = 0;
        end
        par_in = w;
        if (ld_exp) begin
            for (int i = 0; i < 10; i++) begin
                rv[(k + 3 + i) % 32] = 1;
                rb[(k + 3 + i) % 32] = w[lane_of(i)];
                rt[(k + 3 + i) % 32] = tag;
            end
        end
        k++;
        @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        rst_n = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(ser_out == 0, "R6 ser_out in reset", int'(ser_out), 0);
            chk(word_ld == 0, "R6 word_ld in reset", int'(word_ld), 0);
        end
        rst_n = 1;
        k = 0;
        prefill();
    endtask

    function automatic logic [9:0] rnd10();
        return 10'($urandom);
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        @(negedge clk);
        do_reset(3);
        // R3: walking one per word shows the lane order directly.
        for (int c = 0; c < 110; c++)
            cyc((k % 10 == 9) ? 10'(1 << ((k / 10) % 10)) : rnd10(), "R3 lane order");
        // R2/R5: random word at load, junk in every other cycle.
        for (int c = 0; c < 300; c++)
            cyc(rnd10(), "R2 capture, R5 junk ignored");
        // R4: constant patterns back-to-back.
        for (int c = 0; c < 80; c++) begin
            logic [9:0] pat;
            case ((k / 10) % 4)
                0: pat = 10'h3FF;
                1: pat = 10'h2AA;
                2: pat = 10'h155;
                default: pat = 10'h000;
            endcase
            cyc((k % 10 == 9) ? pat : rnd10(), "R4 back-to-back timing");
        end
        // R6: reset in the middle of a word, then resume.
        for (int c = 0; c < 14; c++) cyc(rnd10(), "R4 before reset");
        do_reset(4);
        for (int c = 0; c < 200; c++)
            cyc(rnd10(), "R6 restart then R4 stream");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule